// File: doc/BRIEF.md
# PHY Management Bus Controller

This block lets software run register reads and writes on an external PHY over the two-wire management bus: a clock (MDC) and a bidirectional data line (MDIO). Software programs a clock divisor, the PHY and register addresses and, for writes, a 16-bit value. It then raises one bit in a command register. The controller derives MDC from the system clock and shifts the management frame out MSB first. On reads it releases the line, samples the PHY's answer on rising MDC, and posts the 16-bit result once the frame ends.

The command bits are levels, not pulses. They stay set after the frame and software clears them by writing zero. A frame starts only when a bit goes from 0 to 1. Besides single reads and writes there is a scan mode, which reads the addressed register again and again for as long as its bit is held. Scan mode keeps a link-fail flag up to date from bit 2 of each result. A mode bit drops the 32-bit preamble, and another mode bit holds the whole management logic in reset.

Top module: `mgmt_mdio_ctrl`

## Requirements
- R1: Registers sit at word offsets 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data and 5 status. The first four read back what was written:
  - mode: divisor in [7:0], no-preamble in [8], management reset in [9].
  - command: scan in [0], read in [1], write in [2].
  - address: PHY address in [4:0], register address in [12:8].
  - transmit data: [15:0].
- R2: MDC is low after reset. It changes level every floor(D/2) system clocks, where D is the divisor, and a divisor below 2 counts as 2.
- R3: A frame is 32 ones of preamble, then start bits 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, the 5-bit register address, 2 turnaround bits and 16 data bits, all MSB first.
- R4: With the no-preamble bit set, the frame begins directly with the start bits.
- R5: In a read, the controller releases MDIO (output enable low) for the turnaround and data bits and samples the 16 data bits on rising MDC. The receive data register changes only when a read frame ends.
- R6: A write drives turnaround 10 followed by the transmit data register value.
- R7: Status bit 1 (busy) is high from the second clock edge after a command bit is written from 0 to 1 until the frame ends. In scan mode it stays high until the final scan frame ends.
- R8: A frame starts only on a 0-to-1 change of a command bit. A bit held at 1, or rewritten as 1, starts nothing. A rising bit that arrives while busy is ignored.
- R9: If several command bits rise in the same write, write wins over read and read wins over scan.
- R10: While the scan bit stays set, the addressed register is read back to back. Status bit 2 (not valid) is set from the scan start until the first scan frame completes. Status bit 0 (link fail) takes the inverse of bit 2 of each scan result.
- R11: While mode bit 9 is set, any frame is abandoned, busy is low, MDIO is released and MDC is held low. Clearing the bit lets frames run again.
- R12: After reset, all registers read zero, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Management data driven to the pad |
| mdio_oe | output | 1 | Pad output enable for MDIO |

## Verification
The bench targets the following corner cases:
- Odd divisors and divisors of 0 and 1. A divider that used the raw value would produce the wrong MDC period or stop toggling altogether.
- A command bit that is left set, rewritten as set, or raised while a frame is running. Level-triggered start logic would keep issuing frames in these cases, and it would be seen in the bench's frame count.
- Simultaneous command bits, where a wrong priority shows up as the wrong opcode reaching the PHY model.
- Scan mode, where the PHY changes its link bit between frames. The bench checks both link-fail polarities and the timing of the not-valid flag.
- A management reset in the middle of a frame, followed by a fresh read. Logic that failed to let go of MDIO or left the frame state dirty would return corrupt data on that read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // register word offsets
  localparam int unsigned RA_MODE = 0;
  localparam int unsigned RA_CMD  = 1;
  localparam int unsigned RA_ADDR = 2;
  localparam int unsigned RA_TXD  = 3;
  localparam int unsigned RA_RXD  = 4;
  localparam int unsigned RA_STAT = 5;

  localparam int unsigned BODY_W   = 32;  // start..data, after preamble
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned TA_POS   = 14;  // first turnaround bit in body
  localparam int unsigned DATA_POS = 16;  // first data bit in body

  // system clocks per MDC level
  function automatic logic [15:0] mdc_half(input logic [15:0] div);
    return (div < 16'd2) ? 16'd1 : (div >> 1);
  endfunction

  // frame body after the preamble, MSB first on the wire
  function automatic logic [BODY_W-1:0] frame_body(input logic rd,
                                                   input logic [4:0] pa,
                                                   input logic [4:0] ra,
                                                   input logic [DATA_W-1:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : d)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen import mdio_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             tick,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half      = DIV_W'(mdc_half(16'(div)));
  assign tick      = !hold && (cnt >= half - DIV_W'(1));
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hold) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame import mdio_pkg::*; #(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              start,
  input  logic              start_rd,
  input  logic              no_pre,
  input  logic [4:0]        pa,
  input  logic [4:0]        ra,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              is_rd,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int TOT = PRE_LEN + BODY_W;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0]     cnt;      // bits already placed on the wire
  logic [CW-1:0]     pre_len;
  logic [BODY_W-1:0] body;
  logic              last_bit, in_pre, release_now, sample_now;

  assign last_bit    = (cnt == pre_len + CW'(BODY_W));
  assign in_pre      = (cnt < pre_len);
  assign release_now = is_rd && (cnt >= pre_len + CW'(TA_POS));
  assign sample_now  = is_rd && (cnt > pre_len + CW'(DATA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; is_rd <= 1'b0;
      mdio_out <= 1'b0; mdio_oe <= 1'b0;
      cnt <= '0; pre_len <= '0; body <= '0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (hold) begin
        busy <= 1'b0; mdio_oe <= 1'b0; mdio_out <= 1'b0; cnt <= '0;
      end else if (start && !busy) begin
        busy    <= 1'b1;
        cnt     <= '0;
        is_rd   <= start_rd;
        pre_len <= no_pre ? '0 : CW'(PRE_LEN);
        body    <= frame_body(start_rd, pa, ra, wdata);
      end else if (busy && fall_tick) begin
        if (last_bit) begin
          busy <= 1'b0; done <= 1'b1; mdio_oe <= 1'b0; mdio_out <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
          if (in_pre) begin
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b1;
          end else begin
            mdio_out <= body[BODY_W-1];
            mdio_oe  <= !release_now;
            body     <= {body[BODY_W-2:0], 1'b0};
          end
        end
      end else if (busy && rise_tick && sample_now) begin
        rd_data <= {rd_data[DATA_W-2:0], mdio_in};
      end
    end
  end
endmodule

// File: rtl/mgmt_mdio_ctrl.sv
module mgmt_mdio_ctrl import mdio_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mdc,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe
);
  logic [DIV_W-1:0]  div_q;
  logic              nopre_q, soft_rst;
  logic [2:0]        cmd_q, cmd_prev, cmd_rise;
  logic [4:0]        phy_q, rga_q;
  logic [DATA_W-1:0] txd_q, rx_q, eng_rd;
  logic              link_fail, nvalid, scan_act;
  logic              mdc_tick, rise_tick, fall_tick;
  logic              eng_busy, eng_done, eng_is_rd;
  logic              busy_all, launch_new, relaunch, eng_start, eng_start_rd, new_scan;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[31:16];

  // command sequencing: edge-triggered, write > read > scan
  assign cmd_rise     = cmd_q & ~cmd_prev;
  assign busy_all     = eng_busy || scan_act;
  assign launch_new   = !busy_all && (|cmd_rise);
  assign relaunch     = scan_act && eng_done && cmd_q[0];
  assign eng_start    = !soft_rst && (launch_new || relaunch);
  assign eng_start_rd = relaunch || !cmd_rise[2];
  assign new_scan     = (cmd_rise[2:1] == 2'b00);

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .hold(soft_rst), .div(div_q),
    .mdc(mdc), .tick(mdc_tick), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .hold(soft_rst),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(eng_start), .start_rd(eng_start_rd), .no_pre(nopre_q),
    .pa(phy_q), .ra(rga_q), .wdata(txd_q), .mdio_in(mdio_in),
    .busy(eng_busy), .done(eng_done), .is_rd(eng_is_rd),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_data(eng_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; nopre_q <= 1'b0; soft_rst <= 1'b0;
      cmd_q <= '0; cmd_prev <= '0; phy_q <= '0; rga_q <= '0;
      txd_q <= '0; rx_q <= '0;
      link_fail <= 1'b0; nvalid <= 1'b0; scan_act <= 1'b0;
    end else begin
      cmd_prev <= cmd_q;
      if (reg_wr) begin
        if (reg_addr == AW'(RA_MODE)) begin
          div_q    <= reg_wdata[DIV_W-1:0];
          nopre_q  <= reg_wdata[8];
          soft_rst <= reg_wdata[9];
        end
        if (reg_addr == AW'(RA_CMD))  cmd_q <= reg_wdata[2:0];
        if (reg_addr == AW'(RA_ADDR)) begin
          phy_q <= reg_wdata[4:0];
          rga_q <= reg_wdata[12:8];
        end
        if (reg_addr == AW'(RA_TXD))  txd_q <= reg_wdata[DATA_W-1:0];
      end
      if (eng_done && eng_is_rd) rx_q <= eng_rd;
      if (soft_rst) begin
        scan_act <= 1'b0;
        nvalid   <= 1'b0;
      end else if (eng_start && launch_new) begin
        scan_act <= new_scan;
        nvalid   <= new_scan;
      end else if (eng_done && scan_act) begin
        nvalid    <= 1'b0;
        link_fail <= !eng_rd[2];
        if (!cmd_q[0]) scan_act <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(RA_MODE))
      reg_rdata = 32'(div_q) | (32'(nopre_q) << 8) | (32'(soft_rst) << 9);
    if (reg_addr == AW'(RA_CMD))  reg_rdata = 32'(cmd_q);
    if (reg_addr == AW'(RA_ADDR)) reg_rdata = 32'(phy_q) | (32'(rga_q) << 8);
    if (reg_addr == AW'(RA_TXD))  reg_rdata = 32'(txd_q);
    if (reg_addr == AW'(RA_RXD))  reg_rdata = 32'(rx_q);
    if (reg_addr == AW'(RA_STAT)) reg_rdata = {29'd0, nvalid, busy_all, link_fail};
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdc_tick,
  input logic        fall_tick,
  input logic        soft_rst,
  input logic        mdio_oe,
  input logic        busy_all,
  input logic        frame_done,
  input logic        nvalid,
  input logic [2:0]  cmd_rise,
  input logic [15:0] rx_q
);
  p_mdc_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc_tick && !soft_rst) |=> $stable(mdc));

  p_line_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_tick && !soft_rst) |=> $stable(mdio_oe));

  p_rx_only_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_q));

  p_busy_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_rise) && !busy_all && !soft_rst) |=> busy_all);

  p_nvalid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nvalid) |-> ($past(frame_done) || $past(soft_rst)));

  p_soft_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!mdio_oe && !busy_all));
endmodule

bind mgmt_mdio_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdc_tick(mdc_tick),
  .fall_tick(fall_tick), .soft_rst(soft_rst), .mdio_oe(mdio_oe),
  .busy_all(busy_all), .frame_done(eng_done), .nvalid(nvalid),
  .cmd_rise(cmd_rise), .rx_q(rx_q)
);

// File: tb/mgmt_mdio_ctrl_test.sv
module mgmt_mdio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {is_write, no_pre, div[7:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd4, 5'h01, 5'h02, 16'hA5C3},
    {1'b1, 1'b0, 8'd4, 5'h1F, 5'h04, 16'h1234},
    {1'b0, 1'b1, 8'd2, 5'h10, 5'h1F, 16'hFFFF},
    {1'b1, 1'b1, 8'd7, 5'h00, 5'h00, 16'h8001},
    {1'b0, 1'b0, 8'd0, 5'h0A, 5'h15, 16'h0000},
    {1'b0, 1'b1, 8'd9, 5'h15, 5'h0A, 16'h5A5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_out, mdio_oe, mdio_in;
  logic phy_out = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mdio_in = mdio_oe ? mdio_out : phy_out;

  mgmt_mdio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  int checks = 0;
  int fails = 0;

  // PHY model
  logic [15:0] phy_mem [32];
  bit in_frame = 0;
  int bitn = 0, ones = 0, frames = 0, last_pre = 0;
  int abort_req = 0, abort_ack = 0;
  logic [31:0] body_bits = '0;
  logic [4:0] last_pa = '0, last_ra = '0;
  logic [1:0] last_ta = '0;
  logic last_rd = 1'b0;

  always @(posedge mdc) begin
    if (abort_req != abort_ack) begin
      abort_ack = abort_req; in_frame = 0; ones = 0;
    end
    if (!in_frame) begin
      if (mdio_oe) begin
        if (mdio_out) ones++;
        else begin
          in_frame = 1; bitn = 1; body_bits = '0; last_pre = ones; ones = 0;
        end
      end
    end else begin
      body_bits[31-bitn] = mdio_in;
      bitn++;
      if (bitn == 32) begin
        in_frame = 0;
        last_rd = (body_bits[29:28] == 2'b10);
        last_pa = body_bits[27:23];
        last_ra = body_bits[22:18];
        last_ta = body_bits[17:16];
        if (!last_rd) phy_mem[last_ra] = body_bits[15:0];
        frames++;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && bitn >= 15 && body_bits[29:28] == 2'b10) begin
      if (bitn == 15) phy_out = 1'b0;
      else phy_out = phy_mem[body_bits[22:18]][31-bitn];
    end else phy_out = 1'b1;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_idle(input int lim);
    logic [31:0] s;
    for (int i = 0; i < lim; i++) begin
      rd(3'd5, s);
      if (!s[1]) break;
    end
  endtask

  task automatic mdc_period(input logic [7:0] div, input int exp, input string tag);
    realtime t0, t1;
    wr(3'd0, {24'd0, div});
    @(posedge mdc); @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk(tag, 32'((t1 - t0) / CLK_PERIOD), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R12 register reset", v, 32'd0);
    end
    chk("R12 mdc low", 32'(mdc), 32'd0);
    chk("R12 mdio released", 32'(mdio_oe), 32'd0);

    // R1: readback of programmable fields
    wr(3'd2, 32'h0000_1A13); rd(3'd2, v); chk("R1 address readback", v, 32'h0000_1A13);
    wr(3'd3, 32'h0000_C0DE); rd(3'd3, v); chk("R1 txdata readback", v, 32'h0000_C0DE);
    wr(3'd0, 32'h0000_0105); rd(3'd0, v); chk("R1 mode readback", v, 32'h0000_0105);

    // R2: MDC period
    mdc_period(8'd6, 6, "R2 period div6");
    mdc_period(8'd7, 6, "R2 period div7");
    mdc_period(8'd1, 2, "R2 period div1");
    mdc_period(8'd0, 2, "R2 period div0");

    // vector table: R3 R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      logic [35:0] e;
      e = VEC[k];
      f = frames;
      if (!e[35]) phy_mem[e[20:16]] = e[15:0];
      else phy_mem[e[20:16]] = ~e[15:0];
      wr(3'd0, {22'd0, 1'b0, e[34], e[33:26]});
      wr(3'd2, {19'd0, e[20:16], 3'd0, e[25:21]});
      wr(3'd3, {16'd0, e[15:0]});
      wr(3'd1, 32'd0);
      wr(3'd1, e[35] ? 32'd4 : 32'd2);
      rd(3'd5, v); chk("R7 busy after command edge", 32'(v[1]), 32'd1);
      wait_idle(4000);
      rd(3'd5, v); chk("R7 busy drops at end", 32'(v[1]), 32'd0);
      chk("R3 one frame", 32'(frames - f), 32'd1);
      chk("R3 opcode", 32'(last_rd), 32'(!e[35]));
      chk("R3 phy address", 32'(last_pa), 32'(e[25:21]));
      chk("R3 register address", 32'(last_ra), 32'(e[20:16]));
      chk(e[34] ? "R4 no preamble" : "R3 preamble length", 32'(last_pre), e[34] ? 32'd0 : 32'd32);
      if (e[35]) begin
        chk("R6 write turnaround", 32'(last_ta), 32'd2);
        chk("R6 write data at PHY", 32'(phy_mem[e[20:16]]), 32'(e[15:0]));
      end else begin
        rd(3'd4, v); chk("R5 read data", v, 32'(e[15:0]));
      end
    end

    // R8: held bit, rewritten bit, edge while busy
    wr(3'd0, 32'd4);
    wr(3'd2, 32'h0000_0301);
    phy_mem[3] = 16'h3C3C;
    wr(3'd1, 32'd0);
    wr(3'd1, 32'd2);
    wr(3'd1, 32'd6);
    wait_idle(4000);
    f = frames;
    chk("R8 write edge during busy ignored", 32'(last_rd), 32'd1);
    rd(3'd1, v); chk("R8 command bit stays set", v, 32'd6);
    wr(3'd1, 32'd6);
    repeat (400) @(negedge clk);
    chk("R8 no restart while held", 32'(frames), 32'(f));

    // R9: priority
    wr(3'd1, 32'd0);
    f = frames;
    wr(3'd1, 32'd7);
    wait_idle(4000);
    chk("R9 write wins", 32'(last_rd), 32'd0);
    rd(3'd5, v); chk("R9 scan not started", v, 32'd0);
    chk("R9 single frame", 32'(frames - f), 32'd1);

    // R10: scan mode
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h0000_0101);
    phy_mem[1] = 16'h0000;
    wr(3'd1, 32'd1);
    rd(3'd5, v); chk("R10 not valid at scan start", 32'(v[2]), 32'd1);
    for (int i = 0; i < 4000; i++) begin
      rd(3'd5, v);
      if (!v[2]) break;
    end
    rd(3'd5, v); chk("R10 link fail set, busy held", v, 32'h0000_0003);
    phy_mem[1] = 16'h0004;
    f = frames;
    for (int i = 0; i < 8000 && frames < f + 3; i++) @(negedge clk);
    rd(3'd5, v); chk("R10 link fail cleared", 32'(v[0]), 32'd0);
    rd(3'd4, v); chk("R10 scan result", v, 32'h0000_0004);
    wr(3'd1, 32'd0);
    wait_idle(4000);
    f = frames;
    repeat (400) @(negedge clk);
    chk("R10 scan stops", 32'(frames), 32'(f));

    // R11: management reset mid-frame
    wr(3'd0, 32'd8);
    wr(3'd1, 32'd2);
    repeat (60) @(negedge clk);
    f = frames;
    wr(3'd0, 32'h0000_0208);
    abort_req++;
    repeat (6) @(negedge clk);
    chk("R11 mdc held low", 32'(mdc), 32'd0);
    chk("R11 mdio released", 32'(mdio_oe), 32'd0);
    rd(3'd5, v); chk("R11 not busy", 32'(v[1]), 32'd0);
    chk("R11 frame abandoned", 32'(frames), 32'(f));
    wr(3'd0, 32'd8);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h0000_0300);
    phy_mem[3] = 16'hBEEF;
    wr(3'd1, 32'd2);
    wait_idle(4000);
    rd(3'd4, v); chk("R11 read after release", v, 32'h0000_BEEF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule